// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of conditional branches by running two predictors side by side and letting a trained selector pick between them. One side keys a table of 2-bit saturating counters by the recent outcomes of all branches, which captures correlation between neighbouring branches. The other side is two-level. It first fetches a per-branch history of recent outcomes, chosen by fetch address bits, and then uses that history to address a table of 3-bit saturating counters. A third table of 2-bit counters, keyed by the global outcome history, learns which side is more reliable in each context.

A fetch stage presents a branch address on the predict port. One clock later it receives the final direction and both component directions. When the branch resolves, the pipeline returns the address, the real outcome and the two component directions it was given. The block then trains its counters and shifts the outcome into both histories. Histories change only on resolve, so nothing is speculative and there is no recovery path.

Top module: `tourney_bpred`

## Requirements
- R1: While reset is high, and until the first resolve, every counter sits at its weak not-taken value (2-bit: 1, 3-bit: 3), the selector favours the local side, and both histories are zero. Every predict output therefore reads 0 (not taken).
- R2: The global prediction is the upper bit of a 2-bit saturating counter (taken when the value is 2 or 3). The counter is addressed by the global history.
- R3: The global history is GHIST_W bits wide. On each resolve it shifts left and takes the outcome into bit 0, so bit i holds the outcome i+1 resolves ago (1 = taken). Without a resolve it holds.
- R4: The local history table holds one LHIST_W-bit history per entry, addressed by PC bits [LIDX_W+1:2]. Other PC bits are ignored. On resolve, the addressed entry shifts left and takes the outcome into bit 0.
- R5: The local prediction is the upper bit of a 3-bit counter addressed by the local history, so it is taken for values 4 to 7. The counter saturates at 0 and 7.
- R6: On resolve, the global and local counters move one step toward the outcome, each addressed by the histories held before that resolve. The selector counter, addressed by the global history, changes only when the two returned component directions differ. It steps up when the global side was right and down when the local side was right.
- R7: The final prediction equals the global prediction when the selector counter is 2 or more, and the local prediction otherwise.
- R8: The predict outputs are registered. They reflect the PC and the table state present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Branch address to predict |
| pred_final | output | 1 | Chosen direction (1 = taken) |
| pred_global | output | 1 | Global-history component direction |
| pred_local | output | 1 | Local-history component direction |
| res_valid | input | 1 | Resolve strobe |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Real outcome |
| res_global | input | 1 | Global component direction given at predict time |
| res_local | input | 1 | Local component direction given at predict time |

## Verification
The bench runs a reduced configuration, with 4 global history bits, 8 local entries and 3-bit local histories. This keeps every table small enough that each entry is visited many times. A branch that is always taken drives the counters into saturation. Alternating and period-four loop branches separate the local side, which learns per-branch patterns, from the global side, which sees all branches. A pair of branches where the second copies the first exposes global correlation and trains the selector toward the global side. A long pseudo-random stream spread over all local entries, including addresses that alias through their upper bits, checks every output against an arithmetic model after every step.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // Which component the selector currently favours
  typedef enum logic {SRC_LOCAL = 1'b0, SRC_GLOBAL = 1'b1} src_e;

  function automatic src_e pick_src(input logic sel_hi);
    return sel_hi ? SRC_GLOBAL : SRC_LOCAL;
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
// Table of saturating counters: one combinational read port, one RMW step port.
module tbp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_hi,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);
  localparam logic [CTR_W-1:0] TOP = '1;
  localparam logic [CTR_W-1:0] BOT = '0;

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur, nxt;

  assign cur = mem[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_up && cur != TOP)       nxt = cur + 1'b1;
    else if (!wr_up && cur != BOT) nxt = cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end

  assign rd_hi = mem[rd_idx][CTR_W-1];
endmodule

// File: rtl/tbp_hist_table.sv
// Per-branch outcome histories: two read ports (predict, resolve), one shift port.
module tbp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [HIST_W-1:0] rd_a_hist,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [HIST_W-1:0] rd_b_hist,
  input  logic              wr_en,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[rd_b_idx] <= {mem[rd_b_idx][HIST_W-2:0], wr_bit};
    end
  end

  assign rd_a_hist = mem[rd_a_idx];
  assign rd_b_hist = mem[rd_b_idx];
endmodule

// File: rtl/tourney_bpred.sv
module tourney_bpred #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int SEL_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_final,
  output logic            pred_global,
  output logic            pred_local,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic            res_global,
  input  logic            res_local
);
  import tbp_pkg::*;

  localparam int IDX_LO = 2;
  localparam int IDX_HI = LIDX_W + IDX_LO - 1;

  logic [GHIST_W-1:0] ghist;
  logic [LIDX_W-1:0]  p_idx, r_idx;
  logic [LHIST_W-1:0] p_lhist, r_lhist;
  logic               g_hi, l_hi, s_hi;
  logic               sel_upd;
  logic               unused_pc_bits;

  assign p_idx = pred_pc[IDX_HI:IDX_LO];
  assign r_idx = res_pc[IDX_HI:IDX_LO];
  assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_HI+1], pred_pc[IDX_LO-1:0],
                            res_pc[PC_W-1:IDX_HI+1], res_pc[IDX_LO-1:0]};
  assign sel_upd = res_valid && (res_global != res_local);

  tbp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst(rst),
    .rd_a_idx(p_idx), .rd_a_hist(p_lhist),
    .rd_b_idx(r_idx), .rd_b_hist(r_lhist),
    .wr_en(res_valid), .wr_bit(res_taken)
  );

  tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
    .clk(clk), .rst(rst), .rd_idx(p_lhist), .rd_hi(l_hi),
    .wr_en(res_valid), .wr_idx(r_lhist), .wr_up(res_taken)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
    .clk(clk), .rst(rst), .rd_idx(ghist), .rd_hi(g_hi),
    .wr_en(res_valid), .wr_idx(ghist), .wr_up(res_taken)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .rd_idx(ghist), .rd_hi(s_hi),
    .wr_en(sel_upd), .wr_idx(ghist), .wr_up(res_global == res_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ghist <= '0;
    end else if (res_valid) begin
      ghist <= {ghist[GHIST_W-2:0], res_taken};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_final  <= 1'b0;
      pred_global <= 1'b0;
      pred_local  <= 1'b0;
    end else begin
      pred_global <= g_hi;
      pred_local  <= l_hi;
      pred_final  <= (pick_src(s_hi) == SRC_GLOBAL) ? g_hi : l_hi;
    end
  end
endmodule

// File: rtl/tbp_checks.sv
module tbp_checks #(
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [GHIST_W-1:0] ghist,
  input logic               res_valid,
  input logic               res_taken,
  input logic               pred_final,
  input logic               pred_global,
  input logic               pred_local
);
  // R1: the cycle after reset all predict outputs read not taken
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!pred_final && !pred_global && !pred_local));

  // R7: when both components agree the final direction matches them
  a_r7_agree_passes: assert property (@(posedge clk) disable iff (rst)
    (pred_global == pred_local) |-> (pred_final == pred_global));

  // R3: a resolve shifts its outcome into bit 0 of the global history
  a_r3_ghist_shift: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> (ghist[0] == $past(res_taken)) &&
                  (ghist[GHIST_W-1:1] == $past(ghist[GHIST_W-2:0])));

  // R3: without a resolve the global history holds
  a_r3_ghist_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(ghist));
endmodule

bind tourney_bpred tbp_checks #(.GHIST_W(GHIST_W)) u_chk (
  .clk(clk), .rst(rst), .ghist(ghist), .res_valid(res_valid),
  .res_taken(res_taken), .pred_final(pred_final),
  .pred_global(pred_global), .pred_local(pred_local)
);

// File: tb/tourney_bpred_tb.sv
module tourney_bpred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, GHIST_W = 4, LIDX_W = 3, LHIST_W = 3;
  localparam int GCTR_W = 2, LCTR_W = 3, SEL_W = 2;
  localparam int GD = 1 << GHIST_W, LD = 1 << LIDX_W, HD = 1 << LHIST_W;

  logic clk = 1'b0, rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0, res_pc = '0;
  logic pred_final, pred_global, pred_local;
  logic res_valid = 1'b0, res_taken = 1'b0, res_global = 1'b0, res_local = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  int g_m [GD];
  int s_m [GD];
  int l_m [HD];
  int h_m [LD];
  int gh_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_bpred #(.PC_W(PC_W), .GHIST_W(GHIST_W), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W),
                  .GCTR_W(GCTR_W), .LCTR_W(LCTR_W), .SEL_W(SEL_W)) u_dut (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_final(pred_final),
    .pred_global(pred_global), .pred_local(pred_local), .res_valid(res_valid),
    .res_pc(res_pc), .res_taken(res_taken), .res_global(res_global), .res_local(res_local)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int step_ctr(input int v, input bit up, input int w);
    int top = (1 << w) - 1;
    if (up && v < top) return v + 1;
    if (!up && v > 0) return v - 1;
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < GD; i++) begin g_m[i] = 1; s_m[i] = 1; end
    for (int i = 0; i < HD; i++) l_m[i] = 3;
    for (int i = 0; i < LD; i++) h_m[i] = 0;
    gh_m = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; res_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    // R1: all outputs not taken straight after reset
    check("R1 final", pred_final, 0);
    check("R1 global", pred_global, 0);
    check("R1 local", pred_local, 0);
  endtask

  // One predict-then-resolve round, checked against the model (R2..R8)
  task automatic branch(input logic [PC_W-1:0] pc, input bit taken);
    int idx, eg, el, es, ef;
    idx = int'(pc[LIDX_W+1:2]);
    @(negedge clk); pred_pc = pc; res_valid = 1'b0;
    @(negedge clk);
    eg = g_m[gh_m] >> (GCTR_W - 1);
    el = l_m[h_m[idx]] >> (LCTR_W - 1);
    es = s_m[gh_m] >> (SEL_W - 1);
    ef = es ? eg : el;
    check("R2 R3 R8 global", pred_global, eg);
    check("R4 R5 R8 local", pred_local, el);
    check("R6 R7 final", pred_final, ef);
    res_valid = 1'b1; res_pc = pc; res_taken = taken;
    res_global = pred_global; res_local = pred_local;
    if (pred_global != pred_local)
      s_m[gh_m] = step_ctr(s_m[gh_m], pred_global == taken, SEL_W);
    g_m[gh_m] = step_ctr(g_m[gh_m], taken, GCTR_W);
    l_m[h_m[idx]] = step_ctr(l_m[h_m[idx]], taken, LCTR_W);
    h_m[idx] = ((h_m[idx] << 1) | int'(taken)) & (HD - 1);
    gh_m = ((gh_m << 1) | int'(taken)) & (GD - 1);
    @(negedge clk); res_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();

    // R5: always-taken branch saturates its counter at 7 and stays taken
    for (int i = 0; i < 20; i++) branch(32'h40, 1'b1);
    check("R5 saturated model", l_m[HD-1], 7);
    @(negedge clk); pred_pc = 32'h40; @(negedge clk);
    check("R5 saturated taken", pred_local, 1);

    // R4: alternating branch learned through its local history
    for (int i = 0; i < 24; i++) branch(32'h44, i[0]);
    // R4 R7: loop branch taken three times then not taken
    for (int i = 0; i < 32; i++) branch(32'h48, (i % 4) != 3);
    // R6: correlated pair, second follows the first
    for (int i = 0; i < 40; i++) begin
      branch(32'h50, i[1]);
      branch(32'h54, i[1]);
    end

    // R4: aliasing through upper PC bits plus pseudo-random outcomes on every entry
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch({12'(i), 16'h0, 2'(i >> 3), LIDX_W'(lfsr[5:3]), 2'(i)}, lfsr[0] | lfsr[7]);
    end

    // R1: reset mid-run brings every prediction back to not taken
    do_reset();
    @(negedge clk); pred_pc = 32'h40; @(negedge clk);
    check("R1 after reset local", pred_local, 0);
    check("R1 after reset final", pred_final, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule